// File: doc/BRIEF.md
# Cycle-Budgeted DMA Channel

This block is one channel of a memory-to-memory copy engine. Software programs a source base, a destination base and a control word. The control word holds the unit count, the address stepping of each side, the unit width, repeat, interrupt enable, the start mode and the enable bit. A transfer begins in one of two ways. In start mode 0 it begins the cycle after the enable bit is written from 0 to 1. In any other mode it begins when the start-request line for that mode pulses while the channel is enabled and idle. An active transfer raises `stall` so that the owning processor can be held off.

Copying happens only inside run calls. A caller pulses `run_go` with a signed cycle budget. For each unit the channel issues one read and then one write on a simple memory master. Each unit is charged the wait-state cost of both the source and the destination region. The call ends when the current burst is exhausted or when the budget is no longer positive, and the budget that remains is reported.

In FIFO-feed mode (code 7) a burst is capped at 112 units. The channel then releases `stall` and waits for the next FIFO request, which continues from the working addresses it had reached. Whenever units remain at the end of a call, the remaining count is written back into the control word.

Top module: `dma_channel`

## Requirements
- R1: After reset `ctrl_word` is 0 and `stall`, `irq`, `run_done`, `mem_rd` and `mem_wr` are all low.
- R2: Each unit is one cycle with `mem_rd` high at the working source address, followed directly by one cycle with `mem_wr` high at the working destination address. The write carries the data returned for the read. A run call issues exactly the units its burst and budget allow.
- R3: Control bit 26 set selects 32-bit units, and each address steps by 4. Clear selects 16-bit units, each address steps by 2, and the write data is the low half of the read data with the upper 16 bits zero.
- R4: The source step mode sits in control bits 24:23 and the destination step mode in bits 22:21. Code 0 increments, 1 decrements and 2 holds. Destination code 3 increments and also reloads the working destination from the destination base at every start. Source code 3 holds.
- R5: A unit costs wait(src region) plus wait(dst region), where the region is address bits 27:24. For 16-bit units the waits are: regions 8 and 9 cost 6, region A costs 10, and every other region costs 1. For 32-bit units the waits are: regions 8 and 9 cost 12, region A costs 10, regions 2, 5 and 6 cost 2, and every other region costs 1. A unit starts only while the budget is above zero, so the budget may end negative. `budget_left` reports what is left.
- R6: If units remain when a call ends, the count field (bits 13:0 in the default configuration) holds the remaining count. In a mode other than 7, `stall` stays high.
- R7: When the whole count is done, bit 31 is cleared unless repeat (bit 25) is set. `irq` pulses for one cycle if bit 30 is set. `stall` falls, and `budget_left` is the remaining budget minus 2.
- R8: In start mode 7 (bits 29:27 = 7) a burst moves at most 112 units. `stall` falls after the burst. A later `start_req[7]` resumes from the working addresses reached so far.
- R9: A zero count field at start means the count width's maximum plus one (16384 units by default). The count width is 21 bits when `CPU_IDX` is 0. Otherwise it is 16 bits when `CHAN_IDX` is 3 and 14 bits for any other channel.
- R10: A start request is ignored while the channel is running, while bit 31 is clear, or when it arrives on a line other than the programmed start mode.
- R11: A run call made while no transfer is active pulses `run_done` on the next cycle with `budget_left` equal to the given budget, and produces no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source base, 1 destination base, 2 control |
| reg_wdata | input | 32 | Register write data |
| start_req | input | 8 | Start-request line per start-mode code |
| run_go | input | 1 | Begin a budgeted run call |
| run_budget | input | 32 | Signed cycle budget for the call |
| run_done | output | 1 | One-cycle pulse when the call ends |
| budget_left | output | 32 | Signed budget remaining after the last call |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wide | output | 1 | Current unit width is 32 bits |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| irq | output | 1 | Completion interrupt pulse |
| stall | output | 1 | Processor stall while a transfer is active |
| ctrl_word | output | 32 | Current control word, including the written-back count |

## Verification
The bench goes after the cases where a budget overshoot or a partial burst could be mishandled. A design that tested the budget after a unit instead of before it would copy one unit too few and report a non-negative remainder. A design that forgot to write the count back would leave the original count in the control word, so the next FIFO request would restart a full burst. The bench also programs a zero count in FIFO mode; a wrong cap or a wrong width for the zero-means-maximum rule shows up as a wrong written-back count. A second FIFO request sent mid-burst must be ignored, and honouring it would stretch the burst past its remaining units. Repeated starts with destination mode 3 show whether the destination reload happens, and a missing reload produces write addresses that keep climbing.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  // control word field positions
  localparam int CW_EN      = 31;
  localparam int CW_IRQ     = 30;
  localparam int CW_MODE_LO = 27;
  localparam int CW_WIDE    = 26;
  localparam int CW_RPT     = 25;
  localparam int CW_SRC_LO  = 23;
  localparam int CW_DST_LO  = 21;

  localparam logic [2:0] MODE_NOW  = 3'd0;
  localparam logic [2:0] MODE_FIFO = 3'd7;
  localparam int         FIFO_BURST = 112;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [1:0] STEP_UP     = 2'd0;
  localparam logic [1:0] STEP_DOWN   = 2'd1;
  localparam logic [1:0] STEP_HOLD   = 2'd2;
  localparam logic [1:0] STEP_RELOAD = 2'd3;

  typedef enum logic [1:0] {E_IDLE, E_LOOP, E_RD, E_WR} eng_state_e;

  // count field width chosen by processor side and channel number
  function automatic int count_bits(input int cpu, input int chan);
    if (cpu == 0) return 21;
    return (chan == 3) ? 16 : 14;
  endfunction

  // wait states of one access to a region
  function automatic logic [4:0] region_wait(input logic [3:0] rgn, input logic wide);
    logic [4:0] w;
    case (rgn)
      4'h8, 4'h9:       w = wide ? 5'd12 : 5'd6;
      4'hA:             w = 5'd10;
      4'h2, 4'h5, 4'h6: w = wide ? 5'd2 : 5'd1;
      default:          w = 5'd1;
    endcase
    return w;
  endfunction

  // next working address after one unit
  function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] mode,
                                          input logic wide, input logic is_dst);
    logic [31:0] d;
    d = wide ? 32'd4 : 32'd2;
    case (mode)
      STEP_UP:   return a + d;
      STEP_DOWN: return a - d;
      STEP_HOLD: return a;
      default:   return is_dst ? a + d : a;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic [7:0]       start_req,
  input  logic             running,
  input  logic             wb_en,
  input  logic [CNT_W-1:0] wb_count,
  input  logic             clr_en,
  output logic [31:0]      ctrl,
  output logic [31:0]      src_base,
  output logic [31:0]      dst_base,
  output logic             arm,
  output logic             start
);

  logic [2:0] mode;
  logic       trig_hit;
  logic       now_hit;

  assign mode     = ctrl[CW_MODE_LO +: 3];
  assign trig_hit = (mode != MODE_NOW) && start_req[mode];
  assign now_hit  = arm && (mode == MODE_NOW);
  assign start    = !running && ctrl[CW_EN] && (trig_hit || now_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      src_base <= '0;
      dst_base <= '0;
      arm      <= 1'b0;
    end else begin
      arm <= reg_we && (reg_sel == SEL_CTRL) && reg_wdata[CW_EN] && !ctrl[CW_EN];
      if (reg_we && reg_sel == SEL_SRC) src_base <= reg_wdata;
      if (reg_we && reg_sel == SEL_DST) dst_base <= reg_wdata;
      if (reg_we && reg_sel == SEL_CTRL) begin
        ctrl <= reg_wdata;
      end else begin
        if (wb_en)  ctrl[CNT_W-1:0] <= wb_count;
        if (clr_en) ctrl[CW_EN]     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter bit IS_DST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  input  logic        adv,
  input  logic [1:0]  mode,
  input  logic        wide,
  output logic [31:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= stepped(addr, mode, wide, IS_DST);
  end

endmodule

// File: rtl/dma_chan_cost.sv
module dma_chan_cost
  import dma_chan_pkg::*;
(
  input  logic [3:0] src_rgn,
  input  logic [3:0] dst_rgn,
  input  logic       wide,
  output logic [4:0] cost
);

  assign cost = region_wait(src_rgn, wide) + region_wait(dst_rgn, wide);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic [2:0]       mode,
  input  logic             wide,
  input  logic             rpt,
  input  logic             irq_en,
  input  logic             run_go,
  input  logic [31:0]      run_budget,
  input  logic [4:0]       unit_cost,
  input  logic [31:0]      src_addr,
  input  logic [31:0]      dst_addr,
  input  logic [31:0]      mem_rdata,
  output logic             running,
  output logic             adv,
  output logic             wb_en,
  output logic [CNT_W-1:0] wb_count,
  output logic             clr_en,
  output logic             run_done,
  output logic [31:0]      budget_left,
  output logic             irq,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata
);

  localparam logic [CNT_W:0] CNT_FULL  = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] BURST_CAP = (CNT_W+1)'(FIFO_BURST);

  eng_state_e         state;
  logic [CNT_W:0]     rem;
  logic [CNT_W:0]     iter;
  logic signed [31:0] bud;
  logic [CNT_W:0]     start_rem;
  logic [CNT_W:0]     start_iter;
  logic               go_on;
  logic               fin;
  logic               all_done;

  assign start_rem  = (cnt == '0) ? CNT_FULL : {1'b0, cnt};
  assign start_iter = (mode == MODE_FIFO && start_rem > BURST_CAP) ? BURST_CAP : start_rem;

  assign go_on    = (state == E_LOOP) && (iter != '0) && (bud > 32'sd0);
  assign fin      = (state == E_LOOP) && !go_on;
  assign all_done = (rem == '0);
  assign wb_en    = fin && !all_done;
  assign wb_count = rem[CNT_W-1:0];
  assign clr_en   = fin && all_done && !rpt;

  assign mem_rd    = (state == E_RD);
  assign mem_wr    = (state == E_WR);
  assign adv       = mem_wr;
  assign mem_addr  = mem_wr ? dst_addr : src_addr;
  assign mem_wdata = wide ? mem_rdata : {16'h0, mem_rdata[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= E_IDLE;
      running     <= 1'b0;
      rem         <= '0;
      iter        <= '0;
      bud         <= '0;
      run_done    <= 1'b0;
      budget_left <= '0;
      irq         <= 1'b0;
    end else begin
      run_done <= 1'b0;
      irq      <= 1'b0;
      if (start) begin
        rem     <= start_rem;
        iter    <= start_iter;
        running <= 1'b1;
      end
      case (state)
        E_IDLE: begin
          if (run_go) begin
            if (running) begin
              bud   <= $signed(run_budget);
              state <= E_LOOP;
            end else begin
              run_done    <= 1'b1;
              budget_left <= run_budget;
            end
          end
        end
        E_LOOP: begin
          if (go_on) begin
            state <= E_RD;
          end else begin
            state    <= E_IDLE;
            run_done <= 1'b1;
            if (all_done) begin
              running     <= 1'b0;
              budget_left <= bud - 32'sd2;
              irq         <= irq_en;
            end else begin
              running     <= (iter != '0);
              budget_left <= bud;
            end
          end
        end
        E_RD: state <= E_WR;
        default: begin
          bud   <= bud - $signed({27'd0, unit_cost});
          iter  <= iter - 1'b1;
          rem   <= rem - 1'b1;
          state <= E_LOOP;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_chan_pkg::*;
#(
  parameter int CPU_IDX  = 1,
  parameter int CHAN_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [7:0]  start_req,
  input  logic        run_go,
  input  logic [31:0] run_budget,
  output logic        run_done,
  output logic [31:0] budget_left,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        mem_wide,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        irq,
  output logic        stall,
  output logic [31:0] ctrl_word
);

  localparam int CNT_W = count_bits(CPU_IDX, CHAN_IDX);

  logic [31:0]      ctrl;
  logic [31:0]      src_base;
  logic [31:0]      dst_base;
  logic             arm;
  logic             start;
  logic             running;
  logic             adv;
  logic             wb_en;
  logic [CNT_W-1:0] wb_count;
  logic             clr_en;
  logic [31:0]      src_addr;
  logic [31:0]      dst_addr;
  logic [4:0]       unit_cost;
  logic             dst_reload;

  assign ctrl_word  = ctrl;
  assign stall      = running;
  assign mem_wide   = ctrl[CW_WIDE];
  assign dst_reload = start && (ctrl[CW_DST_LO +: 2] == STEP_RELOAD);

  dma_chan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .start_req(start_req), .running(running), .wb_en(wb_en), .wb_count(wb_count),
    .clr_en(clr_en), .ctrl(ctrl), .src_base(src_base), .dst_base(dst_base),
    .arm(arm), .start(start)
  );

  dma_chan_addr #(.IS_DST(1'b0)) u_src (
    .clk(clk), .rst_n(rst_n), .load(arm), .load_val(src_base), .adv(adv),
    .mode(ctrl[CW_SRC_LO +: 2]), .wide(ctrl[CW_WIDE]), .addr(src_addr)
  );

  dma_chan_addr #(.IS_DST(1'b1)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(arm || dst_reload), .load_val(dst_base), .adv(adv),
    .mode(ctrl[CW_DST_LO +: 2]), .wide(ctrl[CW_WIDE]), .addr(dst_addr)
  );

  dma_chan_cost u_cost (
    .src_rgn(src_addr[27:24]), .dst_rgn(dst_addr[27:24]), .wide(ctrl[CW_WIDE]), .cost(unit_cost)
  );

  dma_chan_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(ctrl[CNT_W-1:0]),
    .mode(ctrl[CW_MODE_LO +: 3]), .wide(ctrl[CW_WIDE]), .rpt(ctrl[CW_RPT]),
    .irq_en(ctrl[CW_IRQ]), .run_go(run_go), .run_budget(run_budget), .unit_cost(unit_cost),
    .src_addr(src_addr), .dst_addr(dst_addr), .mem_rdata(mem_rdata), .running(running),
    .adv(adv), .wb_en(wb_en), .wb_count(wb_count), .clr_en(clr_en), .run_done(run_done),
    .budget_left(budget_left), .irq(irq), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        stall,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        mem_wide,
  input logic [31:0] mem_wdata,
  input logic        run_done
);

  // R7
  irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !stall);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R2
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> mem_wr);
  // R2
  bus_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  // R8
  bus_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_rd || mem_wr) |-> stall);
  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_wide) |-> (mem_wdata[31:16] == 16'h0));
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) run_done |=> !run_done);

endmodule

bind dma_channel dma_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .stall(stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wide(mem_wide), .mem_wdata(mem_wdata), .run_done(run_done)
);

// File: tb/tb_dma_channel.sv
`timescale 1ns/1ps
module tb_dma_channel;

  localparam logic [31:0] PAT = 32'hC3C3_5A5A;
  localparam int FULL = 16384;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  start_req = '0;
  logic        run_go = 1'b0;
  logic [31:0] run_budget = '0;
  logic        run_done, mem_rd, mem_wr, mem_wide, irq, stall;
  logic [31:0] budget_left, mem_addr, mem_wdata, ctrl_word;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .start_req(start_req), .run_go(run_go), .run_budget(run_budget), .run_done(run_done),
    .budget_left(budget_left), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq),
    .stall(stall), .ctrl_word(ctrl_word)
  );

  // memory model: data is a function of the address, one cycle latency
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_addr ^ PAT;

  int checks = 0;
  int fails  = 0;
  int irq_seen = 0;
  bit         q_kind[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];

  // behavioural model state
  logic [31:0] m_src_reg = '0, m_dst_reg = '0, m_ctrl = '0, m_src = '0, m_dst = '0;
  int m_rem = 0, m_iter = 0, exp_irq = 0;
  bit m_run = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bus comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_seen++;
      if (mem_rd || mem_wr) begin
        if (q_kind.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected access actual=%h expected=none", mem_addr);
        end else begin
          automatic bit k = q_kind.pop_front();
          automatic logic [31:0] a = q_addr.pop_front();
          automatic logic [31:0] d = q_data.pop_front();
          chk("R2", "access kind", {31'd0, mem_wr}, {31'd0, k});
          chk("R4", "access address", mem_addr, a);
          if (mem_wr) chk("R3", "write data", mem_wdata, d);
        end
      end
    end
  end

  function automatic int cost_of(input logic [31:0] a, input bit wide);
    int r;
    r = int'(a[27:24]);
    if (r == 8 || r == 9) return wide ? 12 : 6;
    if (r == 10) return 10;
    if (wide && (r == 2 || r == 5 || r == 6)) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] delta(input logic [1:0] m, input bit wide, input bit is_dst);
    logic [31:0] sz;
    sz = wide ? 32'd4 : 32'd2;
    if (m == 2'd0) return sz;
    if (m == 2'd1) return -sz;
    if (m == 2'd3 && is_dst) return sz;
    return 32'd0;
  endfunction

  task automatic model_start();
    int c;
    if (m_run || !m_ctrl[31]) return;
    c = int'(m_ctrl[13:0]);
    m_rem  = (c == 0) ? FULL : c;
    m_iter = (m_ctrl[29:27] == 3'd7 && m_rem > 112) ? 112 : m_rem;
    if (m_ctrl[22:21] == 2'd3) m_dst = m_dst_reg;
    m_run = 1'b1;
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel == 2'd0) m_src_reg = val;
    else if (sel == 2'd1) m_dst_reg = val;
    else begin
      automatic bit old_en = m_ctrl[31];
      m_ctrl = val;
      if (val[31] && !old_en) begin
        m_src = m_src_reg;
        m_dst = m_dst_reg;
        if (val[29:27] == 3'd0) model_start();
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_trig(input int k);
    @(negedge clk);
    start_req = 8'(1 << k);
    @(negedge clk);
    start_req = '0;
    if (k != 0 && k == int'(m_ctrl[29:27])) model_start();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_run(input int budget, input string req);
    int bud;
    bud = budget;
    if (m_run) begin
      while (m_iter > 0 && bud > 0) begin
        automatic logic [31:0] pd = m_src ^ PAT;
        q_kind.push_back(1'b0); q_addr.push_back(m_src); q_data.push_back(32'd0);
        q_kind.push_back(1'b1); q_addr.push_back(m_dst);
        q_data.push_back(m_ctrl[26] ? pd : {16'h0, pd[15:0]});
        bud -= cost_of(m_src, m_ctrl[26]) + cost_of(m_dst, m_ctrl[26]);
        m_src = m_src + delta(m_ctrl[24:23], m_ctrl[26], 1'b0);
        m_dst = m_dst + delta(m_ctrl[22:21], m_ctrl[26], 1'b1);
        m_iter--; m_rem--;
      end
      if (m_rem != 0) begin
        m_ctrl[13:0] = 14'(m_rem);
        m_run = (m_iter != 0);
      end else begin
        if (!m_ctrl[25]) m_ctrl[31] = 1'b0;
        if (m_ctrl[30]) exp_irq++;
        m_run = 1'b0;
        bud -= 2;
      end
    end
    @(negedge clk);
    run_go = 1'b1; run_budget = bud == bud ? 32'(budget) : 32'd0;
    @(negedge clk);
    run_go = 1'b0;
    while (!run_done) @(negedge clk);
    @(negedge clk);
    chk(req, "budget_left", budget_left, 32'(bud));
    chk(req, "ctrl_word", ctrl_word, m_ctrl);
    chk(req, "stall", {31'd0, stall}, {31'd0, m_run});
    chk(req, "irq pulses", 32'(irq_seen), 32'(exp_irq));
    chk("R2", "pending accesses", 32'(q_kind.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ctrl_word", ctrl_word, 32'd0);
    chk("R1", "outputs", {26'd0, stall, irq, run_done, mem_rd, mem_wr, 1'b0}, 32'd0);

    // R11 idle run call
    do_run(50, "R11");

    // R2 R3 R5 R7: immediate, 32-bit, increment both, irq on, 4 units of cost 3
    do_write(2'd0, 32'h0200_0000);
    do_write(2'd1, 32'h0300_0000);
    do_write(2'd2, 32'h0);
    do_write(2'd2, 32'hC400_0004);
    chk("R2", "stall after immediate start", {31'd0, stall}, 32'd1);
    do_run(1000, "R7");
    chk("R5", "budget with completion charge", budget_left, 32'd986);

    // R4 R5 R6: 16-bit, source down, destination hold, repeat, cost 16 per unit
    do_write(2'd0, 32'h0800_0100);
    do_write(2'd1, 32'h0A00_0000);
    do_write(2'd2, 32'h0);
    do_write(2'd2, 32'h82C0_0005);
    do_run(40, "R6");
    chk("R5", "overshoot budget", budget_left, 32'hFFFF_FFF8);
    chk("R6", "written back count", {18'd0, ctrl_word[13:0]}, 32'd2);
    do_run(100, "R7");
    chk("R7", "repeat keeps enable", {31'd0, ctrl_word[31]}, 32'd1);

    // R8 R9 R10: FIFO mode, zero count, 32-bit, destination hold, cost 3
    do_write(2'd0, 32'h0200_0000);
    do_write(2'd1, 32'h0400_0000);
    do_write(2'd2, 32'h0);
    do_write(2'd2, 32'hBC40_0000);
    chk("R10", "no start without request", {31'd0, stall}, 32'd0);
    do_trig(7);
    do_run(100000, "R8");
    chk("R9", "count after capped burst", {18'd0, ctrl_word[13:0]}, 32'(FULL - 112));
    do_trig(3);
    chk("R10", "wrong mode line ignored", {31'd0, stall}, 32'd0);
    do_trig(7);
    do_run(30, "R8");
    do_trig(7); // R10: ignored while running
    do_run(100000, "R10");
    chk("R8", "count after resumed burst", {18'd0, ctrl_word[13:0]}, 32'(FULL - 224));

    // R4: destination mode 3 reloads at each start, 16-bit, mode 1, repeat
    do_write(2'd0, 32'h0000_0010);
    do_write(2'd1, 32'h0200_0020);
    do_write(2'd2, 32'h0);
    do_write(2'd2, 32'h8A60_0003);
    do_trig(1);
    do_run(100, "R4");
    do_trig(1);
    do_run(100, "R4");

    // R10 R11: request while disabled is ignored
    do_write(2'd2, 32'h0);
    do_write(2'd2, 32'h0800_0003);
    do_trig(1);
    chk("R10", "disabled channel stays idle", {31'd0, stall}, 32'd0);
    do_run(77, "R11");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule